// File: doc/BRIEF.md
# Bitmap font glyph renderer

This block draws one character onto a graphic panel whose memory is organised in pages of eight pixel rows. Each font entry is a run of bytes, one byte per pixel column, held in a synchronous read-only memory outside the block. A single `start` pulse supplies the geometry: character code, font base address, first column inside the glyph, glyph width, height in pages, and the number of bytes the font reserves per page row. The block then fetches the glyph bytes and turns them into a stream of panel requests on a valid/ready port. Each request carries either a pixel-column data byte or a cursor command byte.

Glyphs taller than one page are drawn page by page. After every page row except the last, the block moves the cursor one page down and back to the glyph's left edge. Once the bottom row is written, it moves the cursor back up to the top page. The next character therefore starts beside this one, on the same top page. The block also keeps the panel cursor (column and page), loads it from its inputs on `start`, and presents it when it pulses `done`.

Top module: `glyph_render`

## Requirements
- R1: The first ROM read is at address `font_base + col_ofs + char_code * (row_stride * glyph_h)`, computed modulo 2^16. Consecutive data bytes within a page row come from consecutive addresses.
- R2: Each page row produces exactly `glyph_w` data requests (`bus_is_data` = 1), carrying the ROM bytes in address order. A complete glyph makes exactly `glyph_w * glyph_h` ROM reads.
- R3: Between page rows, the read address skips `row_stride - glyph_w` bytes (nothing when they are equal). The legal ranges are `row_stride` ≥ `glyph_w`, widths and strides 1..16, and height 1..8.
- R4: After every page row except the last, the page increments modulo 8 and the column drops by `glyph_w`. Two command requests (`bus_is_data` = 0) then follow in this order: column command 0x40 | col[5:0], then page command 0xB8 | page[2:0].
- R5: After the last page row with `glyph_h` > 1, the page moves back by `glyph_h - 1` modulo 8, followed by the same column-then-page command pair. With `glyph_h` = 1, no command is issued at all.
- R6: The column advances by one, modulo 256, for every accepted data request. When `done` pulses, `cur_col` equals the start column plus `glyph_w` and `cur_page` equals the start page.
- R7: A request stays valid with unchanged byte and kind until `bus_ready` is seen. Nothing advances while `bus_ready` is low.
- R8: `done` is a single-cycle pulse one cycle after the final accepted request. `busy` is high from the cycle after `start` until `done`. A `start` asserted while busy has no effect on the stream.
- R9: Reset leaves the block idle: `busy`, `done`, `bus_valid` and `rom_en` low, with cursor column and page at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a glyph; sampled only when idle |
| char_code | input | 8 | Character index into the font |
| font_base | input | 16 | Font table base address |
| col_ofs | input | 4 | First column inside each font entry |
| glyph_w | input | 5 | Columns drawn per page row (1..16) |
| glyph_h | input | 4 | Glyph height in pages (1..8) |
| row_stride | input | 5 | Font bytes per page row (glyph_w..16) |
| cur_col_in | input | 8 | Cursor column loaded on start |
| cur_page_in | input | 3 | Cursor page loaded on start |
| rom_en | output | 1 | ROM read strobe |
| rom_addr | output | 16 | ROM read address |
| rom_data | input | 8 | ROM data, valid the cycle after the strobe |
| bus_valid | output | 1 | Panel request valid |
| bus_is_data | output | 1 | 1 = pixel data byte, 0 = cursor command |
| bus_byte | output | 8 | Request byte |
| bus_ready | input | 1 | Panel accepts the request |
| busy | output | 1 | Glyph in progress |
| done | output | 1 | One-cycle completion pulse |
| cur_col | output | 8 | Current cursor column |
| cur_page | output | 3 | Current cursor page |

## Verification
A wrong read pointer shows on the first data byte after the fault: the byte no longer matches the font pattern at the expected address. A bad stride skip shows on the first byte of the next page row. A cursor register fault surfaces at the next command pair, which names the wrong column or page. It also shows as a final cursor that differs from the start column plus width, or from the start page, when `done` pulses. Counter faults in the row or column walk change the number of requests and ROM reads, so every such error is visible by the end of the glyph at the latest.

// File: rtl/glyph_pkg.sv
`timescale 1ns/1ps
package glyph_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CAPT,
    ST_DATA,
    ST_CCOL,
    ST_CPAGE,
    ST_DONE
  } walk_st_t;

  // glyph entry start: base + column offset + code * bytes per glyph
  function automatic logic [31:0] glyph_start(input logic [31:0] base,
                                              input logic [31:0] ofs,
                                              input logic [31:0] code,
                                              input logic [31:0] stride,
                                              input logic [31:0] height);
    return base + ofs + code * (stride * height);
  endfunction

  function automatic logic [BYTE_W-1:0] col_cmd(input logic [5:0] col_lo);
    return {2'b01, col_lo};
  endfunction

  function automatic logic [BYTE_W-1:0] page_cmd(input logic [2:0] pg);
    return {5'b10111, pg};
  endfunction

endpackage

// File: rtl/glyph_cursor.sv
`timescale 1ns/1ps
module glyph_cursor #(
  parameter int COL_W  = 8,
  parameter int PAGE_W = 3,
  parameter int DIM_W  = 5,
  parameter int HGT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_load,
  input  logic [COL_W-1:0]  load_col,
  input  logic [PAGE_W-1:0] load_page,
  input  logic              ev_data,
  input  logic              ev_row_step,
  input  logic              ev_rewind,
  input  logic [DIM_W-1:0]  width,
  input  logic [HGT_W-1:0]  height,
  output logic [COL_W-1:0]  col,
  output logic [PAGE_W-1:0] page
);

  logic [COL_W-1:0]  col_nxt;
  logic [PAGE_W-1:0] page_nxt;

  always_comb begin
    col_nxt  = col;
    page_nxt = page;
    if (ev_data)     col_nxt = col_nxt + COL_W'(1);
    if (ev_row_step) begin
      col_nxt  = col_nxt - COL_W'(width);
      page_nxt = page + PAGE_W'(1);
    end
    if (ev_rewind)   page_nxt = page - PAGE_W'(height - HGT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col  <= '0;
      page <= '0;
    end else if (ev_load) begin
      col  <= load_col;
      page <= load_page;
    end else begin
      col  <= col_nxt;
      page <= page_nxt;
    end
  end

  // R6: a lone data beat moves the column by exactly one
  assert_col_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_data && !ev_row_step && !ev_load) |=> (col == $past(col) + COL_W'(1)));

  // R4: a row step moves one page down
  assert_page_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_row_step && !ev_load) |=> (page == $past(page) + PAGE_W'(1)));

  // R4: cursor events never collide
  assert_events_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_load, ev_row_step, ev_rewind}));

endmodule

// File: rtl/glyph_walker.sv
`timescale 1ns/1ps
module glyph_walker
  import glyph_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CODE_W = 8,
  parameter int OFS_W  = 4,
  parameter int DIM_W  = 5,
  parameter int HGT_W  = 4,
  parameter int COL_W  = 8,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] char_code,
  input  logic [ADDR_W-1:0] font_base,
  input  logic [OFS_W-1:0]  col_ofs,
  input  logic [DIM_W-1:0]  width,
  input  logic [HGT_W-1:0]  height,
  input  logic [DIM_W-1:0]  stride,
  output logic              rom_en,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [BYTE_W-1:0] rom_data,
  output logic              bus_valid,
  output logic              bus_is_data,
  output logic [BYTE_W-1:0] bus_byte,
  input  logic              bus_ready,
  input  logic [COL_W-1:0]  cur_col,
  input  logic [PAGE_W-1:0] cur_page,
  output logic              ev_load,
  output logic              ev_data,
  output logic              ev_row_step,
  output logic              ev_rewind,
  output logic [DIM_W-1:0]  width_q,
  output logic [HGT_W-1:0]  height_q,
  output logic              busy,
  output logic              done
);

  walk_st_t          st;
  logic [ADDR_W-1:0] ptr;
  logic [DIM_W-1:0]  bcnt;
  logic [HGT_W-1:0]  rcnt;
  logic [DIM_W-1:0]  stride_q;
  logic [BYTE_W-1:0] dbuf;
  logic              final_q;
  logic              byte_last;
  logic              row_last;
  logic              fire;
  logic [ADDR_W-1:0] next_row_ptr;

  assign byte_last    = (bcnt == width_q - DIM_W'(1));
  assign row_last     = (rcnt == height_q - HGT_W'(1));
  assign fire         = bus_valid && bus_ready;
  assign next_row_ptr = ptr + ADDR_W'(stride_q) - ADDR_W'(width_q) + ADDR_W'(1);

  // named internal events for the cursor and the assertions
  assign ev_load     = (st == ST_IDLE) && start;
  assign ev_data     = (st == ST_DATA) && bus_ready;
  assign ev_row_step = ev_data && byte_last && !row_last;
  assign ev_rewind   = ev_data && byte_last && row_last && (height_q > HGT_W'(1));

  assign rom_en      = (st == ST_FETCH);
  assign rom_addr    = ptr;
  assign bus_valid   = (st == ST_DATA) || (st == ST_CCOL) || (st == ST_CPAGE);
  assign bus_is_data = (st == ST_DATA);
  assign busy        = (st != ST_IDLE);
  assign done        = (st == ST_DONE);

  always_comb begin
    case (st)
      ST_DATA:  bus_byte = dbuf;
      ST_CCOL:  bus_byte = col_cmd(cur_col[5:0]);
      ST_CPAGE: bus_byte = page_cmd(cur_page[2:0]);
      default:  bus_byte = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ptr      <= '0;
      bcnt     <= '0;
      rcnt     <= '0;
      width_q  <= '0;
      height_q <= '0;
      stride_q <= '0;
      dbuf     <= '0;
      final_q  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          width_q  <= width;
          height_q <= height;
          stride_q <= stride;
          ptr      <= ADDR_W'(glyph_start(32'(font_base), 32'(col_ofs),
                                          32'(char_code), 32'(stride), 32'(height)));
          bcnt     <= '0;
          rcnt     <= '0;
          final_q  <= 1'b0;
          st       <= ST_FETCH;
        end
        ST_FETCH: st <= ST_CAPT;
        ST_CAPT: begin
          dbuf <= rom_data;
          st   <= ST_DATA;
        end
        ST_DATA: if (bus_ready) begin
          if (!byte_last) begin
            bcnt <= bcnt + DIM_W'(1);
            ptr  <= ptr + ADDR_W'(1);
            st   <= ST_FETCH;
          end else begin
            bcnt <= '0;
            if (!row_last) begin
              rcnt <= rcnt + HGT_W'(1);
              ptr  <= next_row_ptr;
              st   <= ST_CCOL;
            end else if (height_q > HGT_W'(1)) begin
              final_q <= 1'b1;
              st      <= ST_CCOL;
            end else begin
              st <= ST_DONE;
            end
          end
        end
        ST_CCOL:  if (bus_ready) st <= ST_CPAGE;
        ST_CPAGE: if (bus_ready) st <= final_q ? ST_DONE : ST_FETCH;
        ST_DONE:  st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  // R7: a pending request holds its content until accepted
  assert_hold_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_byte) && $stable(bus_is_data)));

  // R4: an accepted column command is followed by a page command
  assert_col_then_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !bus_is_data && bus_byte[7:6] == 2'b01)
      |=> (bus_valid && !bus_is_data && bus_byte[7:3] == 5'b10111));

  // R8: completion is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: no ROM or panel traffic while idle
  assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_valid && !rom_en));

  // R2: every data request follows a ROM read two cycles earlier or is a held one
  assert_data_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |=> ##1 (bus_valid && bus_is_data));

endmodule

// File: rtl/glyph_render.sv
`timescale 1ns/1ps
module glyph_render
  import glyph_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CODE_W = 8,
  parameter int OFS_W  = 4,
  parameter int DIM_W  = 5,
  parameter int HGT_W  = 4,
  parameter int COL_W  = 8,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] char_code,
  input  logic [ADDR_W-1:0] font_base,
  input  logic [OFS_W-1:0]  col_ofs,
  input  logic [DIM_W-1:0]  glyph_w,
  input  logic [HGT_W-1:0]  glyph_h,
  input  logic [DIM_W-1:0]  row_stride,
  input  logic [COL_W-1:0]  cur_col_in,
  input  logic [PAGE_W-1:0] cur_page_in,
  output logic              rom_en,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [BYTE_W-1:0] rom_data,
  output logic              bus_valid,
  output logic              bus_is_data,
  output logic [BYTE_W-1:0] bus_byte,
  input  logic              bus_ready,
  output logic              busy,
  output logic              done,
  output logic [COL_W-1:0]  cur_col,
  output logic [PAGE_W-1:0] cur_page
);

  logic             ev_load;
  logic             ev_data;
  logic             ev_row_step;
  logic             ev_rewind;
  logic [DIM_W-1:0] width_q;
  logic [HGT_W-1:0] height_q;

  glyph_walker #(
    .ADDR_W(ADDR_W), .CODE_W(CODE_W), .OFS_W(OFS_W), .DIM_W(DIM_W),
    .HGT_W(HGT_W), .COL_W(COL_W), .PAGE_W(PAGE_W)
  ) walker_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .char_code  (char_code),
    .font_base  (font_base),
    .col_ofs    (col_ofs),
    .width      (glyph_w),
    .height     (glyph_h),
    .stride     (row_stride),
    .rom_en     (rom_en),
    .rom_addr   (rom_addr),
    .rom_data   (rom_data),
    .bus_valid  (bus_valid),
    .bus_is_data(bus_is_data),
    .bus_byte   (bus_byte),
    .bus_ready  (bus_ready),
    .cur_col    (cur_col),
    .cur_page   (cur_page),
    .ev_load    (ev_load),
    .ev_data    (ev_data),
    .ev_row_step(ev_row_step),
    .ev_rewind  (ev_rewind),
    .width_q    (width_q),
    .height_q   (height_q),
    .busy       (busy),
    .done       (done)
  );

  glyph_cursor #(
    .COL_W(COL_W), .PAGE_W(PAGE_W), .DIM_W(DIM_W), .HGT_W(HGT_W)
  ) cursor_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_load    (ev_load),
    .load_col   (cur_col_in),
    .load_page  (cur_page_in),
    .ev_data    (ev_data),
    .ev_row_step(ev_row_step),
    .ev_rewind  (ev_rewind),
    .width      (width_q),
    .height     (height_q),
    .col        (cur_col),
    .page       (cur_page)
  );

endmodule

// File: tb/glyph_render_tb.sv
`timescale 1ns/1ps
module glyph_render_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  char_code = '0;
  logic [15:0] font_base = '0;
  logic [3:0]  col_ofs = '0;
  logic [4:0]  glyph_w = 5'd1;
  logic [3:0]  glyph_h = 4'd1;
  logic [4:0]  row_stride = 5'd1;
  logic [7:0]  cur_col_in = '0;
  logic [2:0]  cur_page_in = '0;
  logic        rom_en;
  logic [15:0] rom_addr;
  logic [7:0]  rom_data = '0;
  logic        bus_valid;
  logic        bus_is_data;
  logic [7:0]  bus_byte;
  logic        bus_ready = 1'b1;
  logic        busy;
  logic        done;
  logic [7:0]  cur_col;
  logic [2:0]  cur_page;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  rnd_ready = 1'b0;
  bit  finished = 1'b0;
  int  rd_cnt = 0;
  logic [8:0] got_q[$];
  logic [8:0] exp_q[$];

  always #2.5 clk = ~clk;

  glyph_render dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .char_code(char_code),
    .font_base(font_base), .col_ofs(col_ofs), .glyph_w(glyph_w),
    .glyph_h(glyph_h), .row_stride(row_stride), .cur_col_in(cur_col_in),
    .cur_page_in(cur_page_in), .rom_en(rom_en), .rom_addr(rom_addr),
    .rom_data(rom_data), .bus_valid(bus_valid), .bus_is_data(bus_is_data),
    .bus_byte(bus_byte), .bus_ready(bus_ready), .busy(busy), .done(done),
    .cur_col(cur_col), .cur_page(cur_page)
  );

  // font pattern computed from the address
  function automatic logic [7:0] rom_val(input logic [15:0] a);
    logic [15:0] t;
    t = (a * 16'd29) ^ (a >> 7);
    return t[7:0] ^ t[15:8];
  endfunction

  always_ff @(posedge clk) if (rom_en) rom_data <= rom_val(rom_addr);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ready driver, off the active edge
  initial forever begin
    @(posedge clk);
    #1;
    bus_ready = rnd_ready ? (($urandom % 4) != 0) : 1'b1;
  end

  // monitor
  initial forever begin
    @(negedge clk);
    if (bus_valid && bus_ready) got_q.push_back({bus_is_data, bus_byte});
    if (rom_en) rd_cnt++;
  end

  task automatic build_expect(input logic [7:0] code, input logic [15:0] base,
                              input logic [3:0] ofs, input logic [4:0] w,
                              input logic [3:0] h, input logic [4:0] s,
                              input logic [7:0] c0, input logic [2:0] p0,
                              output logic [7:0] col_f, output logic [2:0] page_f);
    logic [15:0] a;
    logic [7:0]  c;
    logic [2:0]  p;
    a = base + 16'(ofs) + 16'(code) * 16'(s) * 16'(h);
    c = c0;
    p = p0;
    exp_q.delete();
    for (int r = 0; r < int'(h); r++) begin
      for (int b = 0; b < int'(w); b++) begin
        exp_q.push_back({1'b1, rom_val(a)});
        a = a + 16'd1;
        c = c + 8'd1;
      end
      if (r < int'(h) - 1) begin
        a = a + 16'(s) - 16'(w);
        p = p + 3'd1;
        c = c - 8'(w);
        exp_q.push_back({1'b0, 2'b01, c[5:0]});
        exp_q.push_back({1'b0, 5'b10111, p});
      end
    end
    if (h > 4'd1) begin
      p = p - 3'(h - 4'd1);
      exp_q.push_back({1'b0, 2'b01, c[5:0]});
      exp_q.push_back({1'b0, 5'b10111, p});
    end
    col_f  = c;
    page_f = p;
  endtask

  task automatic run_case(input logic [7:0] code, input logic [15:0] base,
                          input logic [3:0] ofs, input logic [4:0] w,
                          input logic [3:0] h, input logic [4:0] s,
                          input logic [7:0] c0, input logic [2:0] p0,
                          input bit poke);
    logic [7:0] col_f;
    logic [2:0] page_f;
    int cyc;
    bit busy_bad;
    build_expect(code, base, ofs, w, h, s, c0, p0, col_f, page_f);
    @(posedge clk);
    #1;
    char_code = code; font_base = base; col_ofs = ofs; glyph_w = w;
    glyph_h = h; row_stride = s; cur_col_in = c0; cur_page_in = p0;
    start = 1'b1;
    got_q.delete();
    rd_cnt = 0;
    @(posedge clk);
    #1;
    start = 1'b0;
    cyc = 0;
    busy_bad = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (done) break;
      if (!busy) busy_bad = 1'b1;
      if (poke && cyc == 3) begin
        // R8: start while busy must be ignored
        start = 1'b1; char_code = ~code; glyph_w = 5'd1; glyph_h = 4'd1;
        cur_col_in = ~c0; cur_page_in = ~p0;
      end
      if (poke && cyc == 4) start = 1'b0;
      if (cyc > 20000) break;
    end
    chk(done, "R8 done seen", 32'(done), 1);
    chk(!busy_bad, "R8 busy while running", 32'(busy_bad), 0);
    chk(got_q.size() == exp_q.size(), "R2 R4 R5 request count",
        32'(got_q.size()), 32'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
      if (i == 0)            chk(got_q[i] == exp_q[i], "R1 first byte", 32'(got_q[i]), 32'(exp_q[i]));
      else if (exp_q[i][8])  chk(got_q[i] == exp_q[i], "R3 data byte", 32'(got_q[i]), 32'(exp_q[i]));
      else                   chk(got_q[i] == exp_q[i], "R4 R5 command byte", 32'(got_q[i]), 32'(exp_q[i]));
    end
    chk(rd_cnt == int'(w) * int'(h), "R2 rom reads", 32'(rd_cnt), 32'(int'(w) * int'(h)));
    chk(cur_col == col_f, "R6 final column", 32'(cur_col), 32'(col_f));
    chk(cur_page == page_f, "R6 final page", 32'(cur_page), 32'(page_f));
    @(negedge clk);
    chk(!done, "R8 done one cycle", 32'(done), 0);
    chk(!busy, "R8 idle after done", 32'(busy), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  // watchdog
  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    logic [4:0] w;
    logic [4:0] s;
    logic [3:0] h;
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(!busy, "R9 busy in reset", 32'(busy), 0);
    chk(!done, "R9 done in reset", 32'(done), 0);
    chk(!bus_valid, "R9 valid in reset", 32'(bus_valid), 0);
    chk(!rom_en, "R9 rom_en in reset", 32'(rom_en), 0);
    chk(cur_col == 8'd0, "R9 column in reset", 32'(cur_col), 0);
    chk(cur_page == 3'd0, "R9 page in reset", 32'(cur_page), 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !bus_valid, "R9 idle after reset", 32'(busy), 0);

    // directed corners
    run_case(8'd65, 16'h1000, 4'd0, 5'd5, 4'd1, 5'd5, 8'd0, 3'd0, 1'b0);    // single page, no commands
    run_case(8'd3, 16'h0200, 4'd1, 5'd6, 4'd2, 5'd8, 8'd60, 3'd3, 1'b0);    // skip 2, column crosses 64
    run_case(8'd255, 16'hFFF0, 4'd15, 5'd16, 4'd8, 5'd16, 8'd0, 3'd0, 1'b0); // address wrap, full height
    run_case(8'd7, 16'h0040, 4'd2, 5'd1, 4'd3, 5'd16, 8'd10, 3'd6, 1'b0);   // page wrap 6,7,0
    run_case(8'd20, 16'h0100, 4'd0, 5'd4, 4'd2, 5'd5, 8'd30, 3'd1, 1'b1);   // start while busy
    run_case(8'd9, 16'h3000, 4'd3, 5'd8, 4'd1, 5'd12, 8'd250, 3'd5, 1'b0);  // column wraps at 256

    // constrained random with ready stalls
    rnd_ready = 1'b1;
    for (int k = 0; k < 30; k++) begin
      w = 5'(1 + ($urandom % 16));
      s = 5'(int'(w) + ($urandom % (17 - int'(w))));
      h = 4'(1 + ($urandom % 8));
      run_case(8'($urandom), 16'($urandom), 4'($urandom), w, h, s,
               8'($urandom), 3'($urandom), (k % 7) == 3);
    end
    finish_run();
  end

endmodule